// File: doc/BRIEF.md
# Serial Flash Data-Buffer Command Responder

This block is the device side of a serial-peripheral link. It models the two 256-byte SRAM staging buffers of a serial flash memory. The host drives the serial clock, serial input and an active-low select. The block decodes each command and either stores the incoming bytes into one of the two buffers or streams buffer contents back on the serial output. The output comes with a separate drive-enable, so the pad can be tri-stated. Main-array access, status polling and clock-rate limits are not part of this block.

All serial pins are oversampled in a single system-clock domain. A synchronizer chain and edge detectors turn SCK and select transitions into one-cycle strobes, so the serial clock must stay well below the system clock (at least four system cycles per SCK phase). The serial link is the only data path. It has no valid/ready pair: SPI gives the slave no way to push back, so every byte the host clocks is taken or produced at once. A write byte lands in its buffer on the rising edge that completes it. The next read byte is fetched from the buffer in the same cycle that the previous one is used up.

Top module: `sfb_responder`

## Requirements
- R1: After reset, and whenever select has been high for three system clocks, `spi_so_oe` is 0.
- R2: A command starts only on a falling edge of select. A rising edge of select aborts whatever is in progress, including a read cut off mid-byte, and the next command after a new falling edge runs normally.
- R3: SI is sampled on SCK rising edges and SO changes on SCK falling edges. Opcode, address and data are all sent most significant bit first.
- R4: Opcode 0x84 writes buffer 1 and 0x87 writes buffer 2. Three address bytes follow the opcode. Only the last address byte (the low 8 bits) gives the start location, and the upper 16 bits have no effect.
- R5: Opcodes 0xD4 and 0xD1 read buffer 1, and 0xD6 and 0xD3 read buffer 2. They take the same three address bytes plus one dummy byte. `spi_so_oe` rises on the first SCK falling edge after the dummy byte, and that edge presents data bit 7.
- R6: During a write or a read, the byte location advances by one after each complete byte and wraps from 255 to 0 with no gap.
- R7: If select rises while a write data byte is incomplete, those bits are discarded and the buffer location keeps its old value.
- R8: Any other opcode changes neither buffer and leaves `spi_so_oe` at 0 until select rises, whatever bytes follow.
- R9: Commands work with SCK idle low (mode 0) and with SCK idle high (mode 3).
- R10: SCK and SI activity while select is high changes no buffer and does not drive SO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Drive enable for `spi_so` (1 drives the pin) |

## Verification
The hardest condition to reach from the pins is a command torn apart by select. Two cases matter: a read dropped after a few bits of a data byte, and a write that ends with a partial byte. Both must leave no trace in the next command. The stimulus drives bit-granular transfers, so select can rise after any number of SCK cycles. It then issues a fresh read over the same locations. The reference model's buffer images show whether the partial byte was dropped and whether the location counter restarted from the new address. Unknown opcodes and clocking with select high are mixed in, and each is followed by a read back of the regions they could have touched.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_OP     = 3'd1,
    PH_ADDR   = 3'd2,
    PH_DUMMY  = 3'd3,
    PH_WDATA  = 3'd4,
    PH_RDATA  = 3'd5,
    PH_IGNORE = 3'd6
  } phase_e;

  localparam logic [7:0] OPC_WR_B1    = 8'h84;
  localparam logic [7:0] OPC_WR_B2    = 8'h87;
  localparam logic [7:0] OPC_RD_B1_HI = 8'hD4;
  localparam logic [7:0] OPC_RD_B1_LO = 8'hD1;
  localparam logic [7:0] OPC_RD_B2_HI = 8'hD6;
  localparam logic [7:0] OPC_RD_B2_LO = 8'hD3;

  localparam int ADDR_BYTES = 3;

endpackage

// File: rtl/sfb_pin_sync.sv
module sfb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic cs_n_raw,
  input  logic si_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic active,
  output logic si_s
);
  // bit 0: sck, bit 1: cs_n, bit 2: si
  localparam logic [2:0] RST_VAL = 3'b010;

  logic [2:0] stg [STAGES];
  logic [2:0] last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= {si_raw, cs_n_raw, sck_raw};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= RST_VAL;
    else        last <= stg[STAGES-1];
  end

  assign sck_rise = stg[STAGES-1][0] & ~last[0];
  assign sck_fall = ~stg[STAGES-1][0] & last[0];
  assign cs_fall  = ~stg[STAGES-1][1] & last[1];
  assign active   = ~stg[STAGES-1][1];
  assign si_s     = stg[STAGES-1][2];

endmodule

// File: rtl/sfb_buf_bank.sv
module sfb_buf_bank #(
  parameter int AW   = 8,
  parameter int NBUF = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NBUF)-1:0] wsel,
  input  logic [AW-1:0]           waddr,
  input  logic [7:0]              wdata,
  input  logic [$clog2(NBUF)-1:0] rsel,
  input  logic [AW-1:0]           raddr,
  output logic [7:0]              rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] rd_each [NBUF];

  genvar b;
  generate
    for (b = 0; b < NBUF; b++) begin : g_buf
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we && (wsel == b[$clog2(NBUF)-1:0])) mem[waddr] <= wdata;
      end
      assign rd_each[b] = mem[raddr];
    end
  endgenerate

  assign rdata = rd_each[rsel];

endmodule

// File: rtl/sfb_cmd_fsm.sv
module sfb_cmd_fsm
  import sfb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_fall,
  input  logic          active,
  input  logic          si_s,
  input  logic [7:0]    rd_data,
  output logic          buf_we,
  output logic          buf_sel,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    wr_data,
  output logic          so,
  output logic          so_oe,
  output phase_e        phase
);
  localparam int ACW = $clog2(ADDR_BYTES);

  logic [6:0]     sh;
  logic [2:0]     bcnt;
  logic [ACW-1:0] acnt;
  logic           is_rd;
  logic           sel_q;
  logic [AW-1:0]  addr;
  logic [7:0]     cur;
  logic [2:0]     ocnt;
  logic           so_q;
  logic           oe_q;
  logic [7:0]     nb;
  logic           capturing;
  logic           byte_done;

  assign nb        = {sh, si_s};
  assign capturing = (phase != PH_IDLE) && (phase != PH_IGNORE);
  assign byte_done = sck_rise && capturing && (bcnt == 3'd7);

  assign buf_we   = byte_done && (phase == PH_WDATA);
  assign buf_sel  = sel_q;
  assign buf_addr = addr;
  assign wr_data  = nb;
  assign so       = so_q;
  assign so_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sh    <= '0;
      bcnt  <= '0;
      acnt  <= '0;
      is_rd <= 1'b0;
      sel_q <= 1'b0;
      addr  <= '0;
      cur   <= '0;
      ocnt  <= '0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!active) begin
      phase <= PH_IDLE;
      bcnt  <= '0;
      oe_q  <= 1'b0;
    end else if (cs_fall) begin
      phase <= PH_OP;
      bcnt  <= '0;
      acnt  <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (sck_rise && capturing) begin
        sh   <= nb[6:0];
        bcnt <= bcnt + 3'd1;
      end
      if (byte_done) begin
        unique case (phase)
          PH_OP: begin
            acnt  <= '0;
            phase <= PH_ADDR;
            unique case (nb)
              OPC_WR_B1:    begin is_rd <= 1'b0; sel_q <= 1'b0; end
              OPC_WR_B2:    begin is_rd <= 1'b0; sel_q <= 1'b1; end
              OPC_RD_B1_HI,
              OPC_RD_B1_LO: begin is_rd <= 1'b1; sel_q <= 1'b0; end
              OPC_RD_B2_HI,
              OPC_RD_B2_LO: begin is_rd <= 1'b1; sel_q <= 1'b1; end
              default:      phase <= PH_IGNORE;
            endcase
          end
          PH_ADDR: begin
            addr <= AW'({addr, nb});
            acnt <= acnt + 1'b1;
            if (acnt == ACW'(ADDR_BYTES - 1))
              phase <= is_rd ? PH_DUMMY : PH_WDATA;
          end
          PH_DUMMY: begin
            phase <= PH_RDATA;
            cur   <= rd_data;
            addr  <= addr + 1'b1;
            ocnt  <= '0;
          end
          PH_WDATA: addr <= addr + 1'b1;
          default: ;
        endcase
      end
      if (sck_fall && (phase == PH_RDATA)) begin
        so_q <= cur[7];
        oe_q <= 1'b1;
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd7) begin
          cur  <= rd_data;
          addr <= addr + 1'b1;
        end else begin
          cur <= {cur[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/sfb_responder.sv
module sfb_responder
  import sfb_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int NBUF = 2;

  logic          sck_rise;
  logic          sck_fall;
  logic          cs_fall;
  logic          active;
  logic          si_s;
  logic          buf_we;
  logic          buf_sel;
  logic [AW-1:0] buf_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  phase_e        phase;

  sfb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_raw  (spi_sck),
    .cs_n_raw (spi_cs_n),
    .si_raw   (spi_si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall),
    .active   (active),
    .si_s     (si_s)
  );

  sfb_cmd_fsm #(.AW(AW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall),
    .active   (active),
    .si_s     (si_s),
    .rd_data  (rd_data),
    .buf_we   (buf_we),
    .buf_sel  (buf_sel),
    .buf_addr (buf_addr),
    .wr_data  (wr_data),
    .so       (spi_so),
    .so_oe    (spi_so_oe),
    .phase    (phase)
  );

  sfb_buf_bank #(.AW(AW), .NBUF(NBUF)) u_bank (
    .clk   (clk),
    .we    (buf_we),
    .wsel  (buf_sel),
    .waddr (buf_addr),
    .wdata (wr_data),
    .rsel  (buf_sel),
    .raddr (buf_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker
  import sfb_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_n,
  input logic   so,
  input logic   so_oe,
  input logic   sck_fall,
  input logic   active,
  input logic   buf_we,
  input phase_e phase
);

  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  a_r2_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (phase == PH_RDATA));

  a_r3_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));

  a_r5_enable_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));

  a_r8_ignored_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> (!buf_we && !so_oe));

  a_r10_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !buf_we);

endmodule

bind sfb_responder sfb_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (spi_cs_n),
  .so       (spi_so),
  .so_oe    (spi_so_oe),
  .sck_fall (sck_fall),
  .active   (active),
  .buf_we   (buf_we),
  .phase    (phase)
);

// File: tb/tb_sfb_responder.sv
module tb_sfb_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so;
  logic so_oe;

  int errors = 0;
  int checks = 0;
  int cs_hi_cnt = 0;
  bit done = 1'b0;

  byte unsigned model [2][256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfb_responder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sck   (sck),
    .spi_cs_n  (cs_n),
    .spi_si    (si),
    .spi_so    (so),
    .spi_so_oe (so_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R1: per-clock comparison of the drive enable while deselected
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
      if (cs_hi_cnt >= 4) check(so_oe == 1'b0, "R1 oe while deselected", so_oe, 0);
    end
  end

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic begin_cmd(input bit mode3);
    @(negedge clk);
    sck = mode3;
    wait_half();
    cs_n = 1'b0;
    wait_half();
  endtask

  task automatic end_cmd(input bit mode3);
    sck = mode3;
    wait_half();
    cs_n = 1'b1;
    wait_half();
    wait_half();
  endtask

  // shifts nbits of tx MSB first; returns SO bits sampled just before each rise
  task automatic xfer(input logic [7:0] tx, input int nbits, input bit exp_oe,
                      input string tag, output logic [7:0] rx);
    bit oe_bad = 1'b0;
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si  = tx[7-i];
      wait_half();
      rx[7-i] = so;
      if (so_oe !== exp_oe) oe_bad = 1'b1;
      sck = 1'b1;
      wait_half();
    end
    check(!oe_bad, tag, !exp_oe, exp_oe);
  endtask

  task automatic do_write(input logic [7:0] op, input logic [23:0] a24, input int n,
                          input int seed, input int tail_bits, input bit mode3);
    logic [7:0] rx;
    int sel = (op == 8'h87) ? 1 : 0;
    int loc = a24[7:0];
    begin_cmd(mode3);
    xfer(op, 8, 1'b0, "R4 opcode oe", rx);
    xfer(a24[23:16], 8, 1'b0, "R4 addr oe", rx);
    xfer(a24[15:8], 8, 1'b0, "R4 addr oe", rx);
    xfer(a24[7:0], 8, 1'b0, "R4 addr oe", rx);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'((seed + k * 37) ^ (k >> 2));
      xfer(d, 8, 1'b0, "R4 write data oe", rx);
      model[sel][loc] = d;
      loc = (loc + 1) % 256;
    end
    if (tail_bits > 0) xfer(8'hC3, tail_bits, 1'b0, "R7 partial oe", rx);
    end_cmd(mode3);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] a24, input int n,
                         input int cut_bits, input bit mode3, input string tag);
    logic [7:0] rx;
    int sel = (op == 8'hD6 || op == 8'hD3) ? 1 : 0;
    int loc = a24[7:0];
    begin_cmd(mode3);
    xfer(op, 8, 1'b0, "R5 opcode oe", rx);
    xfer(a24[23:16], 8, 1'b0, "R5 addr oe", rx);
    xfer(a24[15:8], 8, 1'b0, "R5 addr oe", rx);
    xfer(a24[7:0], 8, 1'b0, "R5 addr oe", rx);
    xfer(8'h00, 8, 1'b0, "R5 dummy oe", rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'hFF, 8, 1'b1, "R5 data oe", rx);
      check(rx === model[sel][loc], tag, rx, model[sel][loc]);
      loc = (loc + 1) % 256;
    end
    if (cut_bits > 0) xfer(8'hFF, cut_bits, 1'b1, "R2 cut read oe", rx);
    end_cmd(mode3);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    check(so_oe === 1'b0, "R1 reset oe", so_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(so_oe === 1'b0, "R1 after reset oe", so_oe, 0);

    // fill both buffers; buffer 2 with nonzero upper address bytes (R4), mode 3 (R9)
    do_write(8'h84, 24'h000000, 256, 3, 0, 1'b0);
    do_write(8'h87, 24'hABCD00, 256, 90, 0, 1'b1);

    // R5 all four read opcodes, R3 bit order, R9 both modes
    do_read(8'hD4, 24'h000000, 12, 0, 1'b0, "R3 R5 read buf1 D4");
    do_read(8'hD1, 24'h000010, 8, 0, 1'b1, "R5 R9 read buf1 D1 mode3");
    do_read(8'hD6, 24'hFFFF80, 8, 0, 1'b0, "R4 R5 read buf2 D6");
    do_read(8'hD3, 24'h0000FD, 6, 0, 1'b1, "R6 R5 read buf2 D3 wrap");

    // R6 write wrap then read across the wrap
    do_write(8'h84, 24'h0000FE, 4, 200, 0, 1'b1);
    do_read(8'hD4, 24'h0000FC, 8, 0, 1'b0, "R6 write wrap readback");

    // R7 partial trailing byte discarded
    do_write(8'h87, 24'h000020, 2, 17, 5, 1'b0);
    do_read(8'hD6, 24'h00001F, 5, 0, 1'b0, "R7 partial byte readback");

    // R8 unknown opcodes followed by write-like traffic
    begin_cmd(1'b0);
    xfer(8'h55, 8, 1'b0, "R8 unknown oe", rx);
    xfer(8'h84, 8, 1'b0, "R8 unknown oe", rx);
    for (int k = 0; k < 8; k++) xfer(8'(k * 29), 8, 1'b0, "R8 unknown oe", rx);
    end_cmd(1'b0);
    begin_cmd(1'b1);
    xfer(8'hD5, 8, 1'b0, "R8 unknown oe", rx);
    for (int k = 0; k < 6; k++) xfer(8'h00, 8, 1'b0, "R8 unknown oe", rx);
    end_cmd(1'b1);
    do_read(8'hD4, 24'h000000, 10, 0, 1'b0, "R8 buf1 unchanged");
    do_read(8'hD3, 24'h000000, 10, 0, 1'b0, "R8 buf2 unchanged");

    // R10 clocking with select high
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      sck = k[0];
      si  = k[1];
      wait_half();
    end
    sck = 1'b0;
    do_read(8'hD4, 24'h000000, 6, 0, 1'b0, "R10 buf1 unchanged");
    do_read(8'hD6, 24'h000020, 6, 0, 1'b1, "R10 buf2 unchanged");

    // R2 read cut mid-byte, then a write and a read must start afresh
    do_read(8'hD1, 24'h000040, 2, 3, 1'b0, "R2 cut read data");
    do_write(8'h87, 24'h000041, 3, 111, 0, 1'b0);
    do_read(8'hD3, 24'h000040, 5, 0, 1'b1, "R2 after abort readback");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule